// File: doc/BRIEF.md
# UART Automatic Modem-Line Flow Controller

This block sits next to a UART receive FIFO and transmit shifter and handles modem-line handshaking in hardware. On the receive side it compares the FIFO fill level with a programmable watermark. When automatic mode is on, it drives the active-low request-to-send line high to pause the far end, and low again to let it resume. Between the two thresholds the line keeps its state, so the level has hysteresis.

On the transmit side it synchronizes the active-low clear-to-send input and produces a hold signal for the transmitter. That hold signal changes only at a character boundary, which is either the end of a stop bit or an idle transmitter. A character that has already started is always sent in full.

A rising edge on either line can set a single shared flow-control interrupt status bit. That bit stays set until the modem-status register is read.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After synchronous reset, `rts_n` is 1, `tx_hold` is 0 and `flow_irq` is 0.
- R2: With `cfg_auto_rts` = 0, `rts_n` equals the inverse of `modem_rts` one clock later.
- R3: With `cfg_auto_rts` = 1 and `modem_rts` = 0, `rts_n` is 1 one clock later, whatever the FIFO level.
- R4: With automatic RTS active (`cfg_auto_rts` = 1, `modem_rts` = 1), `rts_n` is 1 one clock after `rx_level` > `rx_trig_level`.
- R5: With automatic RTS active, `rts_n` is 0 one clock after `rx_level` < `rx_trig_level`. A level equal to the trigger leaves `rts_n` unchanged.
- R6: With `cfg_auto_cts` = 0, `tx_hold` stays 0 whatever `cts_n` does.
- R7: With `cfg_auto_cts` = 1 and `tx_active` = 1, a high `cts_n` does not raise `tx_hold` until a `tx_stop_done` pulse arrives. `tx_hold` then rises on the clock edge that samples the pulse.
- R8: With `cfg_auto_cts` = 1 and `tx_active` = 0, `tx_hold` rises on the third clock edge after `cts_n` goes high. This is two synchronizer stages plus one register.
- R9: With `cfg_auto_cts` = 1, `tx_hold` falls on the third clock edge after `cts_n` returns low, even in mid-character.
- R10: With `cfg_enhanced` = 1, an `rts_n` low-to-high transition sets `flow_irq` one clock after `rts_n` changes, if `int_en_rts` = 1. A synchronized `cts_n` rise sets `flow_irq` on the third edge after the input rises, if `int_en_cts` = 1.
- R11: With `cfg_enhanced` = 0, neither interrupt enable has any effect and `flow_irq` stays 0.
- R12: `flow_irq` stays set until a clock edge with `status_read` = 1 clears it. A new event in that same cycle wins and keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enhanced | input | 1 | Enhanced-function enable; gates the interrupt enables |
| cfg_auto_rts | input | 1 | Automatic RTS mode enable |
| cfg_auto_cts | input | 1 | Automatic CTS mode enable |
| int_en_rts | input | 1 | RTS-rise interrupt enable |
| int_en_cts | input | 1 | CTS-rise interrupt enable |
| modem_rts | input | 1 | Software RTS request (1 = assert) |
| rx_level | input | $clog2(RX_DEPTH+1) | Receive FIFO fill count |
| rx_trig_level | input | $clog2(RX_DEPTH+1) | Flow-control watermark |
| tx_active | input | 1 | Transmitter is shifting a character |
| tx_stop_done | input | 1 | One-cycle pulse when a stop bit completes |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| status_read | input | 1 | Modem-status read strobe, clears the interrupt |
| rts_n | output | 1 | Active-low request-to-send |
| tx_hold | output | 1 | Hold the transmitter at the next character |
| flow_irq | output | 1 | Flow-control interrupt status / request |

## Verification
The bench builds the block with the defaults: a 64-entry FIFO (7-bit level) and a two-stage synchronizer. This makes both the full level of 64 and the trigger of 16 reachable. It places levels 15, 16 and 17 around the trigger to exercise the hysteresis band and both strict comparisons. With a two-stage synchronizer, the three-edge CTS latency and the CTS interrupt timing are known exactly, so each check samples at a single fixed cycle.

// File: rtl/flow_ctrl_pkg.sv
package flow_ctrl_pkg;

    typedef struct packed {
        logic enhanced;
        logic auto_rts;
        logic auto_cts;
        logic ie_rts;
        logic ie_cts;
    } flow_cfg_t;

    typedef enum logic [1:0] {
        LVL_BELOW = 2'd0,
        LVL_AT    = 2'd1,
        LVL_ABOVE = 2'd2
    } lvl_cmp_t;

    function automatic lvl_cmp_t compare_level(input int unsigned lvl, input int unsigned trig);
        if (lvl > trig)
            return LVL_ABOVE;
        else if (lvl < trig)
            return LVL_BELOW;
        return LVL_AT;
    endfunction

endpackage

// File: rtl/rts_watermark.sv
module rts_watermark
    import flow_ctrl_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             modem_rts,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    output logic             rts_n_o
);

    logic     over_q, over_nxt;
    logic     rts_n_q, rts_n_nxt;
    lvl_cmp_t cmp;

    always_comb begin
        cmp      = compare_level(32'(level), 32'(trig));
        over_nxt = over_q;
        case (cmp)
            LVL_ABOVE: over_nxt = 1'b1;
            LVL_BELOW: over_nxt = 1'b0;
            default:   over_nxt = over_q;
        endcase
        if (!modem_rts)
            rts_n_nxt = 1'b1;
        else if (auto_en)
            rts_n_nxt = over_nxt;
        else
            rts_n_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            over_q  <= 1'b0;
            rts_n_q <= 1'b1;
        end else begin
            over_q  <= over_nxt;
            rts_n_q <= rts_n_nxt;
        end
    end

    assign rts_n_o = rts_n_q;

    // R3
    rts_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !modem_rts) |=> rts_n_o);

    // R4
    rts_pause_above_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && modem_rts && (level > trig)) |=> rts_n_o);

endmodule

// File: rtl/cts_gate.sv
module cts_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic cts_n,
    input  logic tx_active,
    input  logic tx_stop_done,
    output logic tx_hold,
    output logic cts_rise
);

    logic [SYNC_STAGES:0] chain;
    logic                 cts_dly;
    logic                 cts_high;
    logic                 hold_q, hold_nxt;

    assign chain[0] = cts_n;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)
                chain[i+1] <= 1'b1;
            else
                chain[i+1] <= chain[i];
        end
    end

    assign cts_high = chain[SYNC_STAGES];

    always_comb begin
        hold_nxt = hold_q;
        if (!auto_en)
            hold_nxt = 1'b0;
        else if (!cts_high)
            hold_nxt = 1'b0;
        else if (tx_stop_done || !tx_active)
            hold_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_dly <= 1'b1;
            hold_q  <= 1'b0;
        end else begin
            cts_dly <= cts_high;
            hold_q  <= hold_nxt;
        end
    end

    assign cts_rise = cts_high & ~cts_dly;
    assign tx_hold  = hold_q;

    // R6
    cts_manual_free_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> !tx_hold);

    // R7
    hold_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_hold) |-> $past(tx_stop_done || !tx_active));

endmodule

// File: rtl/flow_irq.sv
module flow_irq (
    input  logic clk,
    input  logic rst,
    input  logic enhanced,
    input  logic ie_rts,
    input  logic ie_cts,
    input  logic rts_n,
    input  logic cts_rise,
    input  logic status_read,
    output logic irq
);

    logic rts_prev;
    logic irq_q;
    logic rts_evt, cts_evt, set_evt;

    always_comb begin
        rts_evt = rts_n & ~rts_prev & ie_rts;
        cts_evt = cts_rise & ie_cts;
        set_evt = enhanced & (rts_evt | cts_evt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rts_prev <= 1'b1;
            irq_q    <= 1'b0;
        end else begin
            rts_prev <= rts_n;
            if (set_evt)
                irq_q <= 1'b1;
            else if (status_read)
                irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;

    // R12
    irq_clear_by_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(status_read));

    // R11
    irq_needs_enhanced_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(enhanced));

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import flow_ctrl_pkg::*;
#(
    parameter int RX_DEPTH    = 64,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enhanced,
    input  logic             cfg_auto_rts,
    input  logic             cfg_auto_cts,
    input  logic             int_en_rts,
    input  logic             int_en_cts,
    input  logic             modem_rts,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig_level,
    input  logic             tx_active,
    input  logic             tx_stop_done,
    input  logic             cts_n,
    input  logic             status_read,
    output logic             rts_n,
    output logic             tx_hold,
    output logic             flow_irq
);

    flow_cfg_t cfg;
    logic      cts_rise;

    assign cfg = '{enhanced: cfg_enhanced, auto_rts: cfg_auto_rts,
                   auto_cts: cfg_auto_cts, ie_rts: int_en_rts, ie_cts: int_en_cts};

    rts_watermark #(.LVL_W(LVL_W)) u_rts (
        .clk       (clk),
        .rst       (rst),
        .auto_en   (cfg.auto_rts),
        .modem_rts (modem_rts),
        .level     (rx_level),
        .trig      (rx_trig_level),
        .rts_n_o   (rts_n)
    );

    cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk          (clk),
        .rst          (rst),
        .auto_en      (cfg.auto_cts),
        .cts_n        (cts_n),
        .tx_active    (tx_active),
        .tx_stop_done (tx_stop_done),
        .tx_hold      (tx_hold),
        .cts_rise     (cts_rise)
    );

    flow_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .enhanced    (cfg.enhanced),
        .ie_rts      (cfg.ie_rts),
        .ie_cts      (cfg.ie_cts),
        .rts_n       (rts_n),
        .cts_rise    (cts_rise),
        .status_read (status_read),
        .irq         (flow_irq)
    );

    // R2
    rts_manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_auto_rts |=> (rts_n == !$past(modem_rts)));

endmodule

// File: tb/uart_flow_ctrl_test.sv
module uart_flow_ctrl_test;

    localparam int RX_DEPTH = 64;
    localparam int LVL_W    = $clog2(RX_DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_enhanced = 1'b0, cfg_auto_rts = 1'b0, cfg_auto_cts = 1'b0;
    logic             int_en_rts = 1'b0, int_en_cts = 1'b0, modem_rts = 1'b0;
    logic [LVL_W-1:0] rx_level = '0, rx_trig_level = 7'd16;
    logic             tx_active = 1'b0, tx_stop_done = 1'b0, cts_n = 1'b0, status_read = 1'b0;
    logic             rts_n, tx_hold, flow_irq;

    always #5 clk = ~clk;

    uart_flow_ctrl #(.RX_DEPTH(RX_DEPTH), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .cfg_enhanced(cfg_enhanced), .cfg_auto_rts(cfg_auto_rts),
        .cfg_auto_cts(cfg_auto_cts), .int_en_rts(int_en_rts), .int_en_cts(int_en_cts),
        .modem_rts(modem_rts), .rx_level(rx_level), .rx_trig_level(rx_trig_level),
        .tx_active(tx_active), .tx_stop_done(tx_stop_done), .cts_n(cts_n),
        .status_read(status_read), .rts_n(rts_n), .tx_hold(tx_hold), .flow_irq(flow_irq)
    );

    typedef struct packed {
        logic       rts;
        logic       hold;
        logic       irq;
        logic [7:0] req;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   drv_done = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic r, input logic h, input logic i, input int req);
        exp_t e;
        e.rts = r; e.hold = h; e.irq = i; e.req = 8'(req);
        sb_q.push_back(e);
        #1;
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() != 0);
            e = sb_q.pop_front();
            n_checks++;
            if (rts_n !== e.rts || tx_hold !== e.hold || flow_irq !== e.irq) begin
                n_fail++;
                $display("FAIL R%0d: rts_n/tx_hold/flow_irq actual %b%b%b expected %b%b%b",
                         e.req, rts_n, tx_hold, flow_irq, e.rts, e.hold, e.irq);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!drv_done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R1 reset state
        expect_out(1, 0, 0, 1);

        // R2 manual RTS follows inverse of modem_rts
        modem_rts = 1'b1; tick(1); expect_out(0, 0, 0, 2);
        modem_rts = 1'b0; tick(1); expect_out(1, 0, 0, 2);
        tick(1);          expect_out(1, 0, 0, 2);

        // R3 auto on, software request off: stays high
        cfg_auto_rts = 1'b1; rx_level = 7'd40; tick(2); expect_out(1, 0, 0, 3);
        rx_level = 7'd0; tick(2); expect_out(1, 0, 0, 3);

        // R4 / R5 watermark with hysteresis
        modem_rts = 1'b1; rx_level = 7'd10; tick(1); expect_out(0, 0, 0, 5);
        rx_level = 7'd20; tick(1); expect_out(1, 0, 0, 4);
        rx_level = 7'd16; tick(2); expect_out(1, 0, 0, 5);
        rx_level = 7'd15; tick(1); expect_out(0, 0, 0, 5);
        rx_level = 7'd16; tick(2); expect_out(0, 0, 0, 5);
        rx_level = 7'd17; tick(1); expect_out(1, 0, 0, 4);
        rx_level = 7'd64; tick(1); expect_out(1, 0, 0, 4);
        rx_level = 7'd0;  tick(1); expect_out(0, 0, 0, 5);

        // R11 RTS interrupt enable ignored without enhanced bit
        int_en_rts = 1'b1; rx_level = 7'd40; tick(2); expect_out(1, 0, 0, 11);
        rx_level = 7'd0; tick(2); expect_out(0, 0, 0, 11);

        // R10 RTS rise sets interrupt one clock after rts_n
        cfg_enhanced = 1'b1; rx_level = 7'd40; tick(1); expect_out(1, 0, 0, 10);
        tick(1); expect_out(1, 0, 1, 10);

        // R12 read clears
        status_read = 1'b1; tick(1); status_read = 1'b0; expect_out(1, 0, 0, 12);

        // R12 event wins over simultaneous read
        rx_level = 7'd0; tick(2);
        rx_level = 7'd40; tick(1);
        status_read = 1'b1; tick(1); status_read = 1'b0; expect_out(1, 0, 1, 12);
        status_read = 1'b1; tick(1); status_read = 1'b0; expect_out(1, 0, 0, 12);
        rx_level = 7'd0; tick(2); int_en_rts = 1'b0; expect_out(0, 0, 0, 5);

        // R6 manual CTS: never held
        cts_n = 1'b1; tick(4); expect_out(0, 0, 0, 6);
        cts_n = 1'b0; tick(3);

        // R7 mid-character: hold waits for stop bit
        cfg_auto_cts = 1'b1; tx_active = 1'b1; cts_n = 1'b1;
        tick(4); expect_out(0, 0, 0, 7);
        tx_stop_done = 1'b1; tick(1); tx_stop_done = 1'b0; expect_out(0, 1, 0, 7);

        // R9 release after synchronizer latency
        cts_n = 1'b0; tick(2); expect_out(0, 1, 0, 9);
        tick(1); expect_out(0, 0, 0, 9);

        // R8 idle transmitter: three-edge latency
        tx_active = 1'b0; cts_n = 1'b1; tick(2); expect_out(0, 0, 0, 8);
        tick(1); expect_out(0, 1, 0, 8);
        cts_n = 1'b0; tick(3); expect_out(0, 0, 0, 9);

        // R10 CTS rise interrupt
        int_en_cts = 1'b1; cts_n = 1'b1; tick(2); expect_out(0, 0, 0, 10);
        tick(1); expect_out(0, 1, 1, 10);
        status_read = 1'b1; tick(1); status_read = 1'b0; expect_out(0, 1, 0, 12);
        cts_n = 1'b0; tick(3); expect_out(0, 0, 0, 9);

        // R11 CTS interrupt enable ignored without enhanced bit
        cfg_enhanced = 1'b0; cts_n = 1'b1; tick(4); expect_out(0, 1, 0, 11);
        cts_n = 1'b0; tick(3); expect_out(0, 0, 0, 11);

        wait (sb_q.size() == 0);
        #1;
        drv_done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule